// File: doc/BRIEF.md
# Flash Control Key-Unlock Register

This block is the register front end of an embedded flash controller. It holds the controller's control word and keeps it write-protected after reset. Software opens it by writing two fixed key words, one after the other, to a dedicated key register. A second, independent pair of key words, written to its own key register, opens the option-byte controls. That second pair is only listened to while the main control word is already open. Any write that breaks a key sequence closes the relevant lock and holds it closed until the next reset.

The register bus is minimal. It has a word address, write data and a write strobe, and the read data is combinational from the selected register. The lock states, the lockout flags and the held control fields go straight to the flash operation sequencer. No flash array, timing or option storage is modelled here.

Top module: `flash_key_lock`

## Requirements
- R1: After reset, control bit 31 (main lock) and bit 30 (option lock) read 1, bits 27, 17 and the operation field [FIELD_W-1:0] read 0, and both lockout outputs are 0.
- R2: Writing KEY1 (default 0x45670123) and then KEY2 (default 0xCDEF89AB) to the key register (address KEY_ADDR, default 1) clears the main lock on the second write; after only the first word the lock is still set.
- R3: While the main lock is clear, writing OKEY1 (default 0x08192A3B) and then OKEY2 (default 0x4C5D6E7F) to the option key register (address OKEY_ADDR, default 2) clears the option lock.
- R4: Option key writes made while the main lock is set have no effect: the option lock stays set and no option lockout is raised.
- R5: A control write with bit 31 set relocks both the main and the option lock at once; the other bits of that write are ignored.
- R6: A control write with bit 30 set while the main lock is clear sets the option lock and leaves the main lock clear.
- R7: A main key write that does not match the expected word sets key_blocked, keeps the main lock set, and makes every later main key write ignored until reset.
- R8: While the main lock is set, control writes change nothing, including a write of 0 to bit 31.
- R9: A main key write while the main lock is already clear is a wrong key: both locks are set and key_blocked rises.
- R10: With the main lock clear, a control write without bit 31 loads the operation field from bits [FIELD_W-1:0]; bits 17 (option start) and 27 (option reload) are loaded only when the option lock is also clear.
- R11: With the main lock clear, a wrong option key word, or any option key write while the option lock is clear, sets the option lock and okey_blocked; later option key writes are ignored until reset.
- R12: The control register (address CTRL_ADDR, default 0) reads back {bit31 main lock, bit30 option lock, bit27 reload, bit17 option start, [FIELD_W-1:0] field}, every other bit reads 0, and every other address reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_addr | input | ADDR_W | Word address of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the addressed register |
| ctrl_locked | output | 1 | Main lock state |
| opt_locked | output | 1 | Option lock state |
| key_blocked | output | 1 | Main key lockout after a wrong key |
| okey_blocked | output | 1 | Option key lockout after a wrong key |
| op_field | output | FIELD_W | Held operation field |
| opt_start | output | 1 | Held option start request |
| opt_reload | output | 1 | Held option reload request |

## Verification
The bench builds the block with its default parameters: a 16-bit operation field, a 4-bit address with the three registers at word addresses 0, 1 and 2, and the default key words. Address 3 therefore lands on an unmapped word, and the full operation field can be written back and compared. Random traffic is biased towards the next correct key word, and the bench resets often. Because of this, unlock, relock and lockout paths are all reached many times, including a wrong second word after a correct first one.

// File: rtl/fku_pkg.sv
// Shared types and bit positions for the flash key-unlock register.
// Assumes a 32-bit register bus.
package fku_pkg;
    localparam int DATA_W     = 32;
    localparam int LOCK_BIT   = 31;
    localparam int OLOCK_BIT  = 30;
    localparam int RELOAD_BIT = 27;
    localparam int OSTART_BIT = 17;

    typedef enum logic {
        KS_FIRST  = 1'b0,
        KS_SECOND = 1'b1
    } key_state_e;
endpackage

// File: rtl/fku_key_seq.sv
// Two-word key sequence checker.
// Watches writes to one key register while 'armed'. When the guarded lock
// is set, the first word then the second word produces open_pulse. Any
// mismatch, or any write while the guarded lock is already clear, produces
// bad_pulse and latches 'blocked' until reset. Assumes one write per cycle.
module fku_key_seq
    import fku_pkg::*;
#(
    parameter logic [DATA_W-1:0] K_FIRST  = 32'h0,
    parameter logic [DATA_W-1:0] K_SECOND = 32'h0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              armed,
    input  logic              locked,
    output logic              open_pulse,
    output logic              bad_pulse,
    output logic              blocked
);
    key_state_e st_q, st_d;
    logic       blk_q;

    // Next-state and pulse decode for the key sequence.
    always_comb begin
        st_d       = st_q;
        open_pulse = 1'b0;
        bad_pulse  = 1'b0;
        if (!armed) begin
            st_d = KS_FIRST;
        end else if (wr && !blk_q) begin
            if (!locked) begin
                bad_pulse = 1'b1;
            end else if (st_q == KS_FIRST) begin
                if (wdata == K_FIRST) st_d = KS_SECOND;
                else                  bad_pulse = 1'b1;
            end else begin
                if (wdata == K_SECOND) begin
                    open_pulse = 1'b1;
                    st_d       = KS_FIRST;
                end else begin
                    bad_pulse = 1'b1;
                end
            end
        end
        if (bad_pulse) st_d = KS_FIRST;
    end

    // State register and sticky lockout flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= KS_FIRST;
            blk_q <= 1'b0;
        end else begin
            st_q <= st_d;
            if (bad_pulse) blk_q <= 1'b1;
        end
    end

    assign blocked = blk_q;

    AST_BAD_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        bad_pulse |=> blocked); // R7
    AST_NO_OPEN_WHEN_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        blocked |-> !open_pulse); // R11
endmodule

// File: rtl/fku_ctrl_reg.sv
// Control register with main and option locks.
// Applies key results from the two sequence checkers and software writes.
// Assumes key events and control writes never arrive in the same cycle
// (they use different addresses).
module fku_ctrl_reg
    import fku_pkg::*;
#(
    parameter int FIELD_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr,
    input  logic [DATA_W-1:0]  wdata,
    input  logic               main_open,
    input  logic               main_bad,
    input  logic               opt_open,
    input  logic               opt_bad,
    output logic               lock_q,
    output logic               olock_q,
    output logic [FIELD_W-1:0] field_q,
    output logic               ostart_q,
    output logic               reload_q
);
    // Lock and field update, key events taking precedence.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lock_q   <= 1'b1;
            olock_q  <= 1'b1;
            field_q  <= '0;
            ostart_q <= 1'b0;
            reload_q <= 1'b0;
        end else if (main_bad) begin
            lock_q  <= 1'b1;
            olock_q <= 1'b1;
        end else if (main_open) begin
            lock_q <= 1'b0;
        end else if (opt_bad) begin
            olock_q <= 1'b1;
        end else if (opt_open) begin
            olock_q <= 1'b0;
        end else if (wr && !lock_q) begin
            if (wdata[LOCK_BIT]) begin
                lock_q  <= 1'b1;
                olock_q <= 1'b1;
            end else begin
                field_q <= wdata[FIELD_W-1:0];
                if (!olock_q) begin
                    if (wdata[OLOCK_BIT]) begin
                        olock_q <= 1'b1;
                    end else begin
                        ostart_q <= wdata[OSTART_BIT];
                        reload_q <= wdata[RELOAD_BIT];
                    end
                end
            end
        end
    end

    AST_FIELD_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        lock_q |=> $stable(field_q)); // R8
    AST_OPT_UNDER_MAIN: assert property (@(posedge clk) disable iff (!rst_n)
        !olock_q |-> !lock_q); // R4
    AST_OSTART_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ostart_q) |-> $past(!olock_q && !lock_q)); // R10
    AST_BAD_RELOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        main_bad |=> lock_q && olock_q); // R9
endmodule

// File: rtl/flash_key_lock.sv
// Flash controller key-unlock register block (top).
// Decodes the register bus into control and key accesses, runs one key
// sequence checker per lock, and reads back the control word.
// Assumes FIELD_W <= 16 so the field stays clear of bits 17..31.
module flash_key_lock
    import fku_pkg::*;
#(
    parameter int                ADDR_W    = 4,
    parameter int                FIELD_W   = 16,
    parameter logic [ADDR_W-1:0] CTRL_ADDR = 4'd0,
    parameter logic [ADDR_W-1:0] KEY_ADDR  = 4'd1,
    parameter logic [ADDR_W-1:0] OKEY_ADDR = 4'd2,
    parameter logic [31:0]       KEY1      = 32'h4567_0123,
    parameter logic [31:0]       KEY2      = 32'hCDEF_89AB,
    parameter logic [31:0]       OKEY1     = 32'h0819_2A3B,
    parameter logic [31:0]       OKEY2     = 32'h4C5D_6E7F
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_wr,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    output logic               ctrl_locked,
    output logic               opt_locked,
    output logic               key_blocked,
    output logic               okey_blocked,
    output logic [FIELD_W-1:0] op_field,
    output logic               opt_start,
    output logic               opt_reload
);
    logic wr_ctrl, wr_key, wr_okey;
    logic main_open, main_bad, opt_open, opt_bad;

    assign wr_ctrl = bus_wr && (bus_addr == CTRL_ADDR);
    assign wr_key  = bus_wr && (bus_addr == KEY_ADDR);
    assign wr_okey = bus_wr && (bus_addr == OKEY_ADDR);

    fku_key_seq #(.K_FIRST(KEY1), .K_SECOND(KEY2)) u_main_key (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr         (wr_key),
        .wdata      (bus_wdata),
        .armed      (1'b1),
        .locked     (ctrl_locked),
        .open_pulse (main_open),
        .bad_pulse  (main_bad),
        .blocked    (key_blocked)
    );

    fku_key_seq #(.K_FIRST(OKEY1), .K_SECOND(OKEY2)) u_opt_key (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr         (wr_okey),
        .wdata      (bus_wdata),
        .armed      (!ctrl_locked),
        .locked     (opt_locked),
        .open_pulse (opt_open),
        .bad_pulse  (opt_bad),
        .blocked    (okey_blocked)
    );

    fku_ctrl_reg #(.FIELD_W(FIELD_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr        (wr_ctrl),
        .wdata     (bus_wdata),
        .main_open (main_open),
        .main_bad  (main_bad),
        .opt_open  (opt_open),
        .opt_bad   (opt_bad),
        .lock_q    (ctrl_locked),
        .olock_q   (opt_locked),
        .field_q   (op_field),
        .ostart_q  (opt_start),
        .reload_q  (opt_reload)
    );

    // Read mux: only the control register returns data.
    always_comb begin
        bus_rdata = '0;
        if (bus_addr == CTRL_ADDR) begin
            bus_rdata[LOCK_BIT]     = ctrl_locked;
            bus_rdata[OLOCK_BIT]    = opt_locked;
            bus_rdata[RELOAD_BIT]   = opt_reload;
            bus_rdata[OSTART_BIT]   = opt_start;
            bus_rdata[FIELD_W-1:0]  = op_field;
        end
    end

    AST_RESET_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> ctrl_locked && opt_locked); // R1
    AST_UNLOCK_NEEDS_KEY: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ctrl_locked) |-> $past(wr_key && bus_wdata == KEY2)); // R2
    AST_OPT_UNLOCK_NEEDS_KEY: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(opt_locked) |-> $past(wr_okey && bus_wdata == OKEY2 && !ctrl_locked)); // R3
    AST_BLOCKED_STAYS_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        key_blocked |-> ctrl_locked); // R7
endmodule

// File: tb/tb_flash_key_lock.sv
// Self-checking bench: directed corner cases plus seeded random traffic,
// checked against a behavioural model kept in bench functions.
module tb_flash_key_lock;
    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] K1  = 32'h4567_0123;
    localparam logic [31:0] K2  = 32'hCDEF_89AB;
    localparam logic [31:0] OK1 = 32'h0819_2A3B;
    localparam logic [31:0] OK2 = 32'h4C5D_6E7F;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = 4'd0;
    logic [31:0] bus_wdata = 32'd0;
    logic [31:0] bus_rdata;
    logic        ctrl_locked, opt_locked, key_blocked, okey_blocked;
    logic [15:0] op_field;
    logic        opt_start, opt_reload;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // model state
    bit m_lock, m_olock, m_kblk, m_oblk, m_kst, m_okst, m_ostart, m_reload;
    logic [15:0] m_field;

    flash_key_lock dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ctrl_locked(ctrl_locked), .opt_locked(opt_locked),
        .key_blocked(key_blocked), .okey_blocked(okey_blocked),
        .op_field(op_field), .opt_start(opt_start), .opt_reload(opt_reload)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [31:0] model_word();
        logic [31:0] w = 32'd0;
        w[31] = m_lock; w[30] = m_olock; w[27] = m_reload;
        w[17] = m_ostart; w[15:0] = m_field;
        return w;
    endfunction

    function automatic void model_reset();
        m_lock = 1; m_olock = 1; m_kblk = 0; m_oblk = 0;
        m_kst = 0; m_okst = 0; m_ostart = 0; m_reload = 0; m_field = '0;
    endfunction

    function automatic void model_write(input logic [3:0] a, input logic [31:0] d);
        if (a == 4'd0) begin
            if (!m_lock) begin
                if (d[31]) begin m_lock = 1; m_olock = 1; end
                else begin
                    m_field = d[15:0];
                    if (!m_olock) begin
                        if (d[30]) m_olock = 1;
                        else begin m_ostart = d[17]; m_reload = d[27]; end
                    end
                end
            end
        end else if (a == 4'd1) begin
            if (!m_kblk) begin
                if (!m_lock) begin m_kblk = 1; m_lock = 1; m_olock = 1; m_kst = 0; end
                else if (!m_kst) begin
                    if (d == K1) m_kst = 1; else m_kblk = 1;
                end else begin
                    m_kst = 0;
                    if (d == K2) m_lock = 0; else m_kblk = 1;
                end
            end
        end else if (a == 4'd2) begin
            if (!m_lock && !m_oblk) begin
                if (!m_olock) begin m_oblk = 1; m_olock = 1; m_okst = 0; end
                else if (!m_okst) begin
                    if (d == OK1) m_okst = 1; else m_oblk = 1;
                end else begin
                    m_okst = 0;
                    if (d == OK2) m_olock = 0; else m_oblk = 1;
                end
            end
        end
        if (m_lock) m_okst = 0;
    endfunction

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual 0x%08h expected 0x%08h", tag, what, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        chk(tag, "rdata",   bus_rdata,                 model_word());
        chk(tag, "locked",  {31'd0, ctrl_locked},      {31'd0, m_lock});
        chk(tag, "olocked", {31'd0, opt_locked},       {31'd0, m_olock});
        chk(tag, "kblk",    {31'd0, key_blocked},      {31'd0, m_kblk});
        chk(tag, "oblk",    {31'd0, okey_blocked},     {31'd0, m_oblk});
        chk(tag, "fields",  {14'd0, opt_reload, opt_start, op_field},
                            {14'd0, m_reload, m_ostart, m_field});
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0; bus_wr = 0; bus_addr = 4'd0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1;
        model_reset();
    endtask

    task automatic do_write(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 0; bus_addr = 4'd0;
        model_write(a, d);
        #1;
    endtask

    task automatic read_chk(input string tag, input logic [3:0] a, input logic [31:0] exp);
        @(negedge clk);
        bus_addr = a;
        #1 chk(tag, "read", bus_rdata, exp);
        bus_addr = 4'd0;
    endtask

    // watchdog
    initial begin
        #(CLK_PERIOD * 190000);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic [3:0]  a;
        logic [31:0] d;
        int unsigned seed = 32'd20240611;
        void'($urandom(seed));

        do_reset(); #1;
        check_all("R1");

        do_write(4'd0, 32'h0002_ABCD); check_all("R8");
        do_write(4'd0, 32'h0000_0000); check_all("R8");
        do_write(4'd2, OK1); do_write(4'd2, OK2); check_all("R4");

        do_write(4'd1, K1); check_all("R2");
        do_write(4'd1, K2); check_all("R2");
        do_write(4'd0, 32'h0802_1234); check_all("R10");
        do_write(4'd2, OK1); do_write(4'd2, OK2); check_all("R3");
        do_write(4'd0, 32'h0802_5A5A); check_all("R10");
        read_chk("R12", 4'd1, 32'd0);
        read_chk("R12", 4'd3, 32'd0);
        read_chk("R12", 4'd0, 32'h0802_5A5A);
        do_write(4'd0, 32'h4000_0001); check_all("R6");
        do_write(4'd0, 32'h8000_5555); check_all("R5");

        do_reset();
        do_write(4'd1, K1); do_write(4'd1, 32'h0000_0001); check_all("R7");
        do_write(4'd1, K1); do_write(4'd1, K2); check_all("R7");

        do_reset();
        do_write(4'd1, K1); do_write(4'd1, K2);
        do_write(4'd1, K1); check_all("R9");

        do_reset();
        do_write(4'd1, K1); do_write(4'd1, K2);
        do_write(4'd2, OK2); check_all("R11");
        do_write(4'd2, OK1); do_write(4'd2, OK2); check_all("R11");

        do_reset();
        do_write(4'd1, K1); do_write(4'd1, K2);
        do_write(4'd2, OK1); do_write(4'd2, OK2);
        do_write(4'd2, OK1); check_all("R11");

        for (int i = 0; i < 4000; i++) begin
            if (i % 40 == 0) do_reset();
            a = 4'($urandom_range(0, 3));
            if ($urandom_range(0, 9) < 6) begin
                if (a == 4'd1) d = m_kst ? K2 : K1;
                else if (a == 4'd2) d = m_okst ? OK2 : OK1;
                else d = $urandom() & 32'h7FFF_FFFF;
            end else begin
                d = $urandom();
            end
            do_write(a, d);
            check_all("R12");
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule